// File: doc/BRIEF.md
# Register-Mapped Interrupt Controller

This block collects up to 32 interrupt request lines into a single interrupt line for a processor. Each request line is brought into the clock domain through a two-flop synchroniser. A build-time kind mask sets each line as either edge-sensitive or level-sensitive. Captured requests are held in a status register until software clears them. An enable register selects which held requests count as pending. A two-bit master register decides whether any pending request reaches the processor.

Software works through eight 32-bit registers on a simple word-addressed port. Writes happen on a clock edge when the write strobe is high. Read data is combinational from the address. Atomic set-bits and clear-bits ports let several drivers change their own enable bits without a read-modify-write. A vector register names the lowest-numbered pending line, so the handler can branch straight to the right service routine.

Top module: `irq_hub`

## Requirements
- R1: After reset, the enable, status and master registers read zero, the vector register reads 0xFFFFFFFF and irq_o is low. Reset is asserted asynchronously and released two clock edges after rst_n rises.
- R2: A write to byte offset 0x08 replaces the enable register. Enable bits at or above NUM_IN always read zero.
- R3: A write to offset 0x10 ORs the written mask into the enable register. All other enable bits keep their value.
- R4: A write to offset 0x14 clears the enable bits that are 1 in the written mask. All other enable bits keep their value.
- R5: An input whose kind bit is 1 (edge) sets its status bit (offset 0x00, bit i for input i) on a rising edge of its synchronised level. The bit is visible after the third rising clock edge following the input change. Acknowledging the bit clears it even while the input stays high.
- R6: An input whose kind bit is 0 (level) sets its status bit on every cycle the synchronised input is high. An acknowledge while the input is high leaves the bit set. Once the input is low, an acknowledge clears it.
- R7: A write to offset 0x0C clears the status bits that are 1 in the written mask. Writing 0xFFFFFFFF clears every status bit whose input is not requesting.
- R8: Offset 0x04 reads status AND enable. Writes to offsets 0x00, 0x04 and 0x18 change no register.
- R9: Offset 0x18 reads the index of the lowest-numbered pending input. It reads 0xFFFFFFFF when nothing is pending.
- R10: Offset 0x1C holds bit 0 (master on) and bit 1 (hardware interrupt enable). Both read back exactly as written. Its bits above 1 read zero.
- R11: irq_o is high only when both master bits are 1 and at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | NUM_IN | Interrupt request lines, asynchronous |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Byte address; bits 4:2 select the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
Register writes take effect on the edge that samples the strobe, so every write result is checked through a read at the following falling edge. A change on a request line passes through two synchroniser flops and then the status flop. The edge test therefore samples the status register at the second falling edge after the change and expects it clear, and samples again at the third falling edge and expects it set. The pending value, the vector and irq_o are combinational from the registers, so they are checked in the same half cycle as the status they depend on.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned MASTER_W = 2;

  // register select, taken from byte address bits 4:2
  typedef enum logic [SEL_W-1:0] {
    SEL_STAT   = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_ENBL   = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VEC    = 3'd6,
    SEL_MASTER = 3'd7
  } reg_sel_e;

  localparam int unsigned MASTER_ON_BIT = 0;
  localparam int unsigned MASTER_HW_BIT = 1;
endpackage

// File: rtl/irq_hub_rst_sync.sv
module irq_hub_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_hub_capture.sv
module irq_hub_capture #(
  parameter int unsigned          NUM_IN    = 8,
  parameter logic [31:0]          KIND_MASK = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] req_i,
  output logic [NUM_IN-1:0] hit_o
);
  logic [NUM_IN-1:0] sync1_q, sync2_q, prev_q;
  logic [NUM_IN-1:0] sync1_d, sync2_d, prev_d;

  always_comb begin
    sync1_d = req_i;
    sync2_d = sync1_q;
    prev_d  = sync2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= sync1_d;
      sync2_q <= sync2_d;
      prev_q  <= prev_d;
    end
  end

  // kind bits at or above NUM_IN are never looked at
  for (genvar g = 0; g < NUM_IN; g++) begin : g_line
    if (KIND_MASK[g]) begin : g_edge
      assign hit_o[g] = sync2_q[g] & ~prev_q[g];
    end else begin : g_level
      assign hit_o[g] = sync2_q[g];
    end
  end
endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
  import irq_hub_pkg::*;
#(
  parameter int unsigned NUM_IN = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  reg_sel_e            sel_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic [NUM_IN-1:0]   hit_i,
  output logic [NUM_IN-1:0]   en_o,
  output logic [NUM_IN-1:0]   stat_o,
  output logic [MASTER_W-1:0] master_o
);
  logic [NUM_IN-1:0]   en_q, en_d;
  logic [NUM_IN-1:0]   stat_q, stat_d;
  logic [MASTER_W-1:0] master_q, master_d;
  logic                en_ce, master_ce;
  logic [NUM_IN-1:0]   wmask;
  logic [NUM_IN-1:0]   ack_mask;

  assign wmask = wdata_i[NUM_IN-1:0];

  always_comb begin
    en_ce     = 1'b0;
    en_d      = en_q;
    master_ce = wr_i && (sel_i == SEL_MASTER);
    master_d  = wdata_i[MASTER_W-1:0];
    ack_mask  = '0;
    if (wr_i) begin
      unique case (sel_i)
        SEL_ENBL:  begin en_ce = 1'b1; en_d = wmask;          end
        SEL_SETEN: begin en_ce = 1'b1; en_d = en_q | wmask;   end
        SEL_CLREN: begin en_ce = 1'b1; en_d = en_q & ~wmask;  end
        SEL_ACK:   ack_mask = wmask;
        default:   ;
      endcase
    end
    // a new capture wins over an acknowledge in the same cycle
    stat_d = (stat_q & ~ack_mask) | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (en_ce)  en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         master_q <= '0;
    else if (master_ce) master_q <= master_d;
  end

  assign en_o     = en_q;
  assign stat_o   = stat_q;
  assign master_o = master_q;
endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio #(
  parameter int unsigned NUM_IN = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [NUM_IN-1:0] req_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned NUM_IN    = 8,
  parameter logic [31:0] KIND_MASK = 32'h0000_010F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_req_i,
  input  logic              bus_wr_i,
  input  logic [4:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic                rst_sync_n;
  logic [NUM_IN-1:0]   hit;
  logic [NUM_IN-1:0]   en_q, stat_q, pend;
  logic [MASTER_W-1:0] master_q;
  logic                vec_any;
  logic [IDX_W-1:0]    vec_idx;
  reg_sel_e            sel;

  assign sel = reg_sel_e'(bus_addr_i[ADDR_W-1:2]);

  irq_hub_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  irq_hub_capture #(.NUM_IN(NUM_IN), .KIND_MASK(KIND_MASK)) i_capture (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req_i (irq_req_i),
    .hit_o (hit)
  );

  irq_hub_regs #(.NUM_IN(NUM_IN)) i_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_i     (bus_wr_i),
    .sel_i    (sel),
    .wdata_i  (bus_wdata_i),
    .hit_i    (hit),
    .en_o     (en_q),
    .stat_o   (stat_q),
    .master_o (master_q)
  );

  assign pend = stat_q & en_q;

  irq_hub_prio #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) i_prio (
    .req_i (pend),
    .any_o (vec_any),
    .idx_o (vec_idx)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (sel)
      SEL_STAT:   bus_rdata_o[NUM_IN-1:0] = stat_q;
      SEL_PEND:   bus_rdata_o[NUM_IN-1:0] = pend;
      SEL_ENBL:   bus_rdata_o[NUM_IN-1:0] = en_q;
      SEL_VEC:    begin
        if (vec_any) bus_rdata_o[IDX_W-1:0] = vec_idx;
        else         bus_rdata_o = '1;
      end
      SEL_MASTER: bus_rdata_o[MASTER_W-1:0] = master_q;
      default:    bus_rdata_o = '0;
    endcase
  end

  assign irq_o = master_q[MASTER_ON_BIT] & master_q[MASTER_HW_BIT] & vec_any;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int unsigned NUM_IN = 8,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic [2:0]        sel,
  input logic [31:0]       wdata,
  input logic [NUM_IN-1:0] en_q,
  input logic [NUM_IN-1:0] stat_q,
  input logic [1:0]        master_q,
  input logic              vec_any,
  input logic [IDX_W-1:0]  vec_idx,
  input logic              irq
);
  // R3
  set_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 3'd4) |=> ((en_q & $past(wdata[NUM_IN-1:0])) == $past(wdata[NUM_IN-1:0])));

  // R4
  clr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 3'd5) |=> ((en_q & $past(wdata[NUM_IN-1:0])) == '0));

  // R10
  master_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 3'd7) |=> (master_q == $past(wdata[1:0])));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (master_q == 2'b11 && (stat_q & en_q) != '0));

  // R9
  vec_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_any |-> (((stat_q & en_q) >> vec_idx) & NUM_IN'(1)) != '0);

  // R8
  pend_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (sel == 3'd0 || sel == 3'd1 || sel == 3'd6)) |=> $stable(en_q) && $stable(master_q));
endmodule

bind irq_hub irq_hub_chk #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr       (bus_wr_i),
  .sel      (bus_addr_i[4:2]),
  .wdata    (bus_wdata_i),
  .en_q     (en_q),
  .stat_q   (stat_q),
  .master_q (master_q),
  .vec_any  (vec_any),
  .vec_idx  (vec_idx),
  .irq      (irq_o)
);

// File: tb/test_irq_hub.sv
module test_irq_hub;
  localparam int unsigned N = 8;
  localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_EN = 5'h08, A_ACK = 5'h0C,
                         A_SET = 5'h10, A_CLR = 5'h14, A_VEC = 5'h18, A_MST = 5'h1C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          wr = 1'b0;
  logic [4:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  irq_hub #(.NUM_IN(N), .KIND_MASK(32'h0000_010F)) i_irq_hub (
    .clk(clk), .rst_n(rst_n), .irq_req_i(req), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(A_EN, v);   check("R1 enable", v, 32'h0);
    bus_read(A_STAT, v); check("R1 status", v, 32'h0);
    bus_read(A_MST, v);  check("R1 master", v, 32'h0);
    bus_read(A_VEC, v);  check("R1 vector", v, 32'hFFFF_FFFF);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    bus_write(A_EN, 32'h0000_0005);  bus_read(A_EN, v); check("R2 write", v, 32'h05);
    bus_write(A_SET, 32'h0000_0030); bus_read(A_EN, v); check("R3 set", v, 32'h35);
    bus_write(A_CLR, 32'h0000_0011); bus_read(A_EN, v); check("R4 clear", v, 32'h24);
    bus_write(A_EN, 32'hFFFF_FFFF);  bus_read(A_EN, v); check("R2 width", v, 32'hFF);
    bus_write(A_EN, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    @(negedge clk); req[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_read(A_STAT, v); check("R5 not yet", v, 32'h0);
    @(negedge clk); bus_read(A_STAT, v); check("R5 latched", v, 32'h04);
    bus_write(A_ACK, 32'h04);
    @(negedge clk); bus_read(A_STAT, v); check("R5 ack held", v, 32'h0);
    req[2] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_level();
    logic [31:0] v;
    @(negedge clk); req[5] = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(A_STAT, v); check("R6 latched", v, 32'h20);
    bus_write(A_ACK, 32'h20);
    bus_read(A_STAT, v); check("R6 relatch", v, 32'h20);
    req[5] = 1'b0;
    repeat (4) @(negedge clk);
    bus_write(A_ACK, 32'h20);
    bus_read(A_STAT, v); check("R6 cleared", v, 32'h0);
  endtask

  task automatic t_pend_vec();
    logic [31:0] v;
    @(negedge clk); req[1] = 1'b1; req[6] = 1'b1;
    repeat (4) @(negedge clk);
    req[1] = 1'b0; req[6] = 1'b0;
    repeat (4) @(negedge clk);
    bus_read(A_STAT, v); check("R5 two lines", v, 32'h42);
    bus_read(A_VEC, v);  check("R9 none enabled", v, 32'hFFFF_FFFF);
    bus_write(A_EN, 32'h40);
    bus_read(A_PEND, v); check("R8 pending", v, 32'h40);
    bus_read(A_VEC, v);  check("R9 single", v, 32'd6);
    bus_write(A_SET, 32'h02);
    bus_read(A_VEC, v);  check("R9 lowest", v, 32'd1);
    bus_write(A_PEND, 32'h0); bus_write(A_STAT, 32'h0); bus_write(A_VEC, 32'h0);
    bus_read(A_STAT, v); check("R8 status kept", v, 32'h42);
    bus_read(A_EN, v);   check("R8 enable kept", v, 32'h42);
  endtask

  task automatic t_master();
    logic [31:0] v;
    bus_write(A_MST, 32'h1); check("R11 only on", {31'b0, irq}, 32'h0);
    bus_write(A_MST, 32'h2); check("R11 only hw", {31'b0, irq}, 32'h0);
    bus_write(A_MST, 32'hFFFF_FFFF);
    bus_read(A_MST, v);      check("R10 readback", v, 32'h3);
    check("R11 both", {31'b0, irq}, 32'h1);
    bus_write(A_EN, 32'h0);  check("R11 nothing pending", {31'b0, irq}, 32'h0);
    bus_write(A_EN, 32'h42);
  endtask

  task automatic t_ack_all();
    logic [31:0] v;
    bus_write(A_ACK, 32'h02);
    bus_read(A_STAT, v); check("R7 one bit", v, 32'h40);
    bus_write(A_ACK, 32'hFFFF_FFFF);
    bus_read(A_STAT, v); check("R7 all", v, 32'h0);
    check("R11 after ack", {31'b0, irq}, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_enable();
    t_edge();
    t_level();
    t_pend_vec();
    t_master();
    t_ack_all();
    finish_run();
  end
endmodule